// File: doc/BRIEF.md
# Parallel PRBS Generator and Error Checker

This block is one test lane for a serial link. The generator side emits a pseudorandom bit pattern WORD_W bits per enabled clock cycle. The checker side takes a received word stream of the same width and counts bit errors in it. A static select input picks one of five standard maximal-length patterns, three of them sent complemented.

The generator is a Fibonacci shift register, unrolled so that each enabled cycle performs WORD_W steps. The checker runs the same register with a different input: it shifts in the received bits rather than its own feedback. Its residue, the feedback XOR the incoming bit, is zero for a clean stream. The checker therefore locks on after one register length of received data and needs no seeding. Residue ones are added to a saturating error counter. A lock flag reports a programmable run of clean words.

Top module: `prbs_lane`

## Requirements
- R1: The pattern select encodes 0 = x^7+x^6+1, 1 = x^9+x^5+1, 2 = x^15+x^14+1, 3 = x^23+x^18+1, 4 = x^31+x^28+1. Codes 5, 6 and 7 behave exactly like code 0.
- R2: Let L be the pattern length and T its middle exponent. Each generator step computes the XOR of the bit shifted in L steps earlier and the bit shifted in T steps earlier, shifts that value in, and emits it. After reset the register holds all ones.
- R3: Each cycle with gen_en high performs WORD_W steps. The registered gen_word takes the first step's bit in its MSB and the last step's bit in its LSB, and changes at the clock edge that samples gen_en.
- R4: For codes 2, 3 and 4 every bit of gen_word is complemented.
- R5: While gen_en is low, gen_word and the generator state hold.
- R6: The checker shifts in received bits, complementing them first for codes 2, 3 and 4. An error-free stream gives zero errors. A single flipped received bit at stream position g counts one error at each of g, g+T and g+L that falls in a counted word.
- R7: After reset, the first ceil(L/WORD_W) words with chk_valid high only fill the checker register and add no errors.
- R8: Each counted word adds its number of residue ones to err_count, which saturates at 2^CNT_W-1 and never decreases except at reset.
- R9: While chk_valid is low, chk_word is ignored: err_count, locked and the checker state hold.
- R10: locked sets at the edge ending a counted clean word that brings the run of consecutive clean counted words to at least lock_thresh. Any counted word with an error clears it and restarts the run.
- R11: Synchronous reset (rst high at a clock edge) clears gen_word, err_count and locked, reloads the generator seed and restarts the fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pat_sel | input | 3 | Pattern select, static while running |
| lock_thresh | input | LOCK_W | Clean-word run length that sets lock |
| gen_en | input | 1 | Advance generator by one word |
| gen_word | output | WORD_W | Generated word, first bit in MSB |
| chk_valid | input | 1 | Received word valid |
| chk_word | input | WORD_W | Received word, first bit in MSB |
| err_count | output | CNT_W | Saturating bit error count |
| locked | output | 1 | Run of clean words reached threshold |

## Verification
The generator output is looped back into the checker for every pattern code, including an unused code. Each run carries either no error or one flipped bit at a chosen stream position. A clean run of a complemented pattern separates correct receive-side complementing from a checker that sees every bit wrong. A single flip placed inside, straddling, or past the fill window tells the fill rule apart from the spread of one error over the two tap distances. A fully complemented stream drives the counter through exact multiples of the word width into saturation. Idle gaps fed with garbage words show that neither side moves without its enable.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
   localparam int REG_W = 31;
   typedef logic [2:0] pat_sel_t;
   typedef logic [4:0] bit_idx_t;

   // index of the oldest stage used (pattern length - 1)
   function automatic bit_idx_t pat_msb(input pat_sel_t s);
      case (s)
         3'd1:    return 5'd8;
         3'd2:    return 5'd14;
         3'd3:    return 5'd22;
         3'd4:    return 5'd30;
         default: return 5'd6;
      endcase
   endfunction

   // index of the middle tap stage (middle exponent - 1)
   function automatic bit_idx_t pat_tap(input pat_sel_t s);
      case (s)
         3'd1:    return 5'd4;
         3'd2:    return 5'd13;
         3'd3:    return 5'd17;
         3'd4:    return 5'd27;
         default: return 5'd5;
      endcase
   endfunction

   function automatic logic pat_inv(input pat_sel_t s);
      return (s == 3'd2) || (s == 3'd3) || (s == 3'd4);
   endfunction
endpackage

// File: rtl/prbs_step.sv
module prbs_step
   import prbs_pkg::*;
#(
   parameter int WORD_W   = 8,
   parameter bit FEED_FWD = 1'b0
)(
   input  pat_sel_t            sel_i,
   input  logic [REG_W-1:0]    st_i,
   input  logic [WORD_W-1:0]   din_i,
   output logic [REG_W-1:0]    st_o,
   output logic [WORD_W-1:0]   dout_o
);
   bit_idx_t msb, tap;
   assign msb = pat_msb(sel_i);
   assign tap = pat_tap(sel_i);

   generate
      if (FEED_FWD) begin : g_ffwd
         // checker form: received bits enter the register
         always_comb begin
            logic [REG_W-1:0] s;
            logic fb;
            s = st_i;
            dout_o = '0;
            for (int b = WORD_W - 1; b >= 0; b--) begin
               fb = s[msb] ^ s[tap];
               dout_o[b] = fb ^ din_i[b];
               s = {s[REG_W-2:0], din_i[b]};
            end
            st_o = s;
         end
      end else begin : g_fback
         // generator form: feedback (with optional data) enters the register
         always_comb begin
            logic [REG_W-1:0] s;
            logic fb;
            s = st_i;
            dout_o = '0;
            for (int b = WORD_W - 1; b >= 0; b--) begin
               fb = s[msb] ^ s[tap] ^ din_i[b];
               dout_o[b] = fb;
               s = {s[REG_W-2:0], fb};
            end
            st_o = s;
         end
      end
   endgenerate
endmodule

// File: rtl/prbs_err_acc.sv
module prbs_err_acc
   import prbs_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int CNT_W  = 32,
   parameter int LOCK_W = 8
)(
   input  logic               clk,
   input  logic               rst,
   input  pat_sel_t           sel_i,
   input  logic               valid_i,
   input  logic [WORD_W-1:0]  res_i,
   input  logic [LOCK_W-1:0]  thresh_i,
   output logic [CNT_W-1:0]   err_cnt_o,
   output logic               locked_o
);
   localparam int FILL_MAX = (REG_W + WORD_W - 1) / WORD_W;
   localparam int FW       = $clog2(FILL_MAX + 1);
   localparam int PW       = $clog2(WORD_W + 1);

   logic [FW-1:0]     fill_q, fill_need;
   logic [PW-1:0]     pop;
   logic [CNT_W:0]    sum;
   logic [LOCK_W-1:0] run_q, run_nx;
   logic              counted;

   // ceil(L / WORD_W) with L = msb + 1
   assign fill_need = FW'((int'(pat_msb(sel_i)) + WORD_W) / WORD_W);
   assign counted   = (fill_q >= fill_need);

   always_comb begin
      pop = '0;
      for (int b = 0; b < WORD_W; b++) pop = pop + PW'(res_i[b]);
   end

   assign sum    = {1'b0, err_cnt_o} + {{(CNT_W + 1 - PW){1'b0}}, pop};
   assign run_nx = (&run_q) ? run_q : run_q + LOCK_W'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         fill_q    <= '0;
         err_cnt_o <= '0;
         run_q     <= '0;
         locked_o  <= 1'b0;
      end else if (valid_i) begin
         if (!counted) begin
            fill_q <= fill_q + FW'(1);
         end else if (pop != '0) begin
            err_cnt_o <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
            run_q     <= '0;
            locked_o  <= 1'b0;
         end else begin
            run_q <= run_nx;
            if (run_nx >= thresh_i) locked_o <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/prbs_lane.sv
module prbs_lane
   import prbs_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int CNT_W  = 32,
   parameter int LOCK_W = 8
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        pat_sel,
   input  logic [LOCK_W-1:0] lock_thresh,
   input  logic              gen_en,
   output logic [WORD_W-1:0] gen_word,
   input  logic              chk_valid,
   input  logic [WORD_W-1:0] chk_word,
   output logic [CNT_W-1:0]  err_count,
   output logic              locked
);
   generate
      if (WORD_W < 1) begin : g_bad_word
         $error("WORD_W must be at least 1");
      end
      if (CNT_W < $clog2(WORD_W + 1)) begin : g_bad_cnt
         $error("CNT_W too small to hold one word of errors");
      end
      if (LOCK_W < 1) begin : g_bad_lock
         $error("LOCK_W must be at least 1");
      end
   endgenerate

   logic [WORD_W-1:0] inv_mask;
   assign inv_mask = {WORD_W{pat_inv(pat_sel)}};

   // generator
   logic [REG_W-1:0]  gen_st_q, gen_st_nx;
   logic [WORD_W-1:0] gen_bits;

   prbs_step #(.WORD_W(WORD_W), .FEED_FWD(1'b0)) u_gen_step (
      .sel_i (pat_sel),
      .st_i  (gen_st_q),
      .din_i ('0),
      .st_o  (gen_st_nx),
      .dout_o(gen_bits)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         gen_st_q <= '1;
         gen_word <= '0;
      end else if (gen_en) begin
         gen_st_q <= gen_st_nx;
         gen_word <= gen_bits ^ inv_mask;
      end
   end

   // checker
   logic [REG_W-1:0]  chk_st_q, chk_st_nx;
   logic [WORD_W-1:0] residue;

   prbs_step #(.WORD_W(WORD_W), .FEED_FWD(1'b1)) u_chk_step (
      .sel_i (pat_sel),
      .st_i  (chk_st_q),
      .din_i (chk_word ^ inv_mask),
      .st_o  (chk_st_nx),
      .dout_o(residue)
   );

   always_ff @(posedge clk) begin
      if (rst)            chk_st_q <= '0;
      else if (chk_valid) chk_st_q <= chk_st_nx;
   end

   prbs_err_acc #(.WORD_W(WORD_W), .CNT_W(CNT_W), .LOCK_W(LOCK_W)) u_acc (
      .clk      (clk),
      .rst      (rst),
      .sel_i    (pat_sel),
      .valid_i  (chk_valid),
      .res_i    (residue),
      .thresh_i (lock_thresh),
      .err_cnt_o(err_count),
      .locked_o (locked)
   );
endmodule

// File: rtl/prbs_lane_chk.sv
module prbs_lane_chk #(
   parameter int WORD_W = 8,
   parameter int CNT_W  = 32
)(
   input logic              clk,
   input logic              rst,
   input logic              gen_en,
   input logic [WORD_W-1:0] gen_word,
   input logic              chk_valid,
   input logic [CNT_W-1:0]  err_count,
   input logic              locked
);
   logic armed = 1'b0;
   always_ff @(posedge clk) if (rst) armed <= 1'b1;

   // R8
   err_mono_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      !$past(rst) |-> err_count >= $past(err_count));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      !chk_valid |=> $stable(err_count) && $stable(locked));

   // R5
   gen_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      !gen_en |=> $stable(gen_word));

   // R10
   lock_set_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      $rose(locked) |-> $past(chk_valid));

   // R10
   lock_clr_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      $fell(locked) |-> $past(chk_valid) || $past(rst));

   // R11
   rst_clear_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      $past(rst) |-> err_count == '0 && !locked && gen_word == '0);
endmodule

bind prbs_lane prbs_lane_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_sva (
   .clk      (clk),
   .rst      (rst),
   .gen_en   (gen_en),
   .gen_word (gen_word),
   .chk_valid(chk_valid),
   .err_count(err_count),
   .locked   (locked)
);

// File: tb/prbs_lane_tb.sv
`timescale 1ns/1ps
module prbs_lane_tb;
   localparam int W  = 8;
   localparam int CW = 6;
   localparam int LW = 4;
   localparam int NV = 9;
   // {sel[2:0], flip position[7:0] (255 = none), words[4:0]}
   localparam logic [15:0] TBL [NV] = '{
      {3'd0, 8'd255, 5'd10}, {3'd0, 8'd20, 5'd10}, {3'd1, 8'd3,  5'd10},
      {3'd2, 8'd10,  5'd10}, {3'd3, 8'd40, 5'd12}, {3'd4, 8'd0,  5'd10},
      {3'd4, 8'd7,   5'd10}, {3'd4, 8'd75, 5'd10}, {3'd5, 8'd30, 5'd10}};

   logic clk = 1'b0, rst = 1'b1, gen_en = 1'b0, chk_valid = 1'b0, locked;
   logic [2:0] pat_sel = 3'd0;
   logic [LW-1:0] lock_thresh = 4'd3;
   logic [W-1:0] gen_word, chk_word = '0;
   logic [CW-1:0] err_count;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   logic [30:0] m_gs;

   always #4 clk = ~clk;

   prbs_lane #(.WORD_W(W), .CNT_W(CW), .LOCK_W(LW)) u_dut (
      .clk(clk), .rst(rst), .pat_sel(pat_sel), .lock_thresh(lock_thresh),
      .gen_en(gen_en), .gen_word(gen_word), .chk_valid(chk_valid),
      .chk_word(chk_word), .err_count(err_count), .locked(locked));

   // R1 pattern table as seen by the bench
   function automatic int m_len(input logic [2:0] s);
      case (s) 3'd1: return 9; 3'd2: return 15; 3'd3: return 23; 3'd4: return 31; default: return 7; endcase
   endfunction
   function automatic int m_mid(input logic [2:0] s);
      case (s) 3'd1: return 5; 3'd2: return 14; 3'd3: return 18; 3'd4: return 28; default: return 6; endcase
   endfunction
   function automatic logic m_inv(input logic [2:0] s);
      return (s >= 3'd2) && (s <= 3'd4);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_word(output logic [W-1:0] w);
      logic fb;
      for (int b = W - 1; b >= 0; b--) begin
         fb = m_gs[m_len(pat_sel) - 1] ^ m_gs[m_mid(pat_sel) - 1];
         w[b] = fb ^ m_inv(pat_sel);
         m_gs = {m_gs[29:0], fb};
      end
   endtask

   task automatic do_reset(input logic [2:0] s);
      @(negedge clk);
      pat_sel = s; rst = 1'b1; gen_en = 1'b0; chk_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_gs = '1;
   endtask

   // one generated word, checked, then looped back with flip mask
   task automatic do_word(input logic [W-1:0] flip, input string tag);
      logic [W-1:0] exp;
      gen_en = 1'b1;
      @(negedge clk);
      gen_en = 1'b0;
      model_word(exp);
      check(gen_word == exp, tag, int'(gen_word), int'(exp));
      chk_word = gen_word ^ flip; chk_valid = 1'b1;
      @(negedge clk);
      chk_valid = 1'b0;
   endtask

   function automatic int exp_errs(input logic [2:0] s, input int g, input int nw);
      int l, fill, tot, n;
      int pos [3];
      if (g == 255) return 0;
      l = m_len(s);
      fill = ((l + W - 1) / W) * W;
      tot = nw * W;
      pos = '{g, g + m_mid(s), g + l};
      n = 0;
      foreach (pos[i]) if (pos[i] >= fill && pos[i] < tot) n++;
      return n;
   endfunction

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [2:0] s;
      int g, nw, e;
      logic [W-1:0] held;
      string tag;

      // R11 reset state
      do_reset(3'd0);
      check(gen_word == '0, "R11 gen_word", int'(gen_word), 0);
      check(err_count == '0, "R11 err_count", int'(err_count), 0);
      check(locked == 1'b0, "R11 locked", int'(locked), 0);

      // R1 R2 R3 R4 R6 R7: loopback table
      for (int v = 0; v < NV; v++) begin
         s  = TBL[v][15:13];
         g  = int'(TBL[v][12:5]);
         nw = int'(TBL[v][4:0]);
         do_reset(s);
         tag = (s > 3'd4) ? "R1 gen" : (m_inv(s) ? "R4 gen" : "R2 R3 gen");
         for (int w = 0; w < nw; w++) begin
            if (g != 255 && g / W == w) do_word(W'(1) << (W - 1 - g % W), tag);
            else do_word('0, tag);
         end
         e = exp_errs(s, g, nw);
         check(int'(err_count) == e, "R6 R7 error count", int'(err_count), e);
      end

      // R5 R9: idle gaps with garbage on the receive side
      do_reset(3'd2);
      for (int w = 0; w < 3; w++) do_word('0, "R4 gen");
      held = gen_word;
      chk_word = 8'hA5;
      repeat (3) @(negedge clk);
      check(gen_word == held, "R5 gen hold", int'(gen_word), int'(held));
      check(err_count == '0, "R9 idle count", int'(err_count), 0);
      for (int w = 0; w < 3; w++) do_word('0, "R5 gen resume");
      check(err_count == '0, "R9 checker state kept", int'(err_count), 0);

      // R10 lock with threshold 3 on a 9-bit pattern (two fill words)
      do_reset(3'd1);
      for (int w = 0; w < 4; w++) do_word('0, "R3 gen");
      check(locked == 1'b0, "R10 not yet locked", int'(locked), 0);
      do_word('0, "R3 gen");
      check(locked == 1'b1, "R10 locked", int'(locked), 1);
      do_word(8'h10, "R3 gen");
      check(locked == 1'b0, "R10 cleared on error", int'(locked), 0);
      check(err_count != '0, "R10 error seen", int'(err_count), 1);

      // R7 R8: fully complemented stream, 8 errors per counted word
      do_reset(3'd0);
      do_word(8'hFF, "R3 gen");
      check(err_count == '0, "R7 fill word", int'(err_count), 0);
      for (int w = 1; w < 8; w++) do_word(8'hFF, "R3 gen");
      check(int'(err_count) == 56, "R8 accumulate", int'(err_count), 56);
      do_word(8'hFF, "R3 gen");
      check(int'(err_count) == 63, "R8 saturate", int'(err_count), 63);
      for (int w = 9; w < 12; w++) do_word(8'hFF, "R3 gen");
      check(int'(err_count) == 63, "R8 stays saturated", int'(err_count), 63);

      // R11 reset in mid-run
      do_reset(3'd0);
      check(err_count == '0, "R11 mid-run err_count", int'(err_count), 0);
      check(gen_word == '0, "R11 mid-run gen_word", int'(gen_word), 0);
      do_word('0, "R11 seed reload");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule